// File: doc/BRIEF.md
# Run-Time Configurable Sticky Status and Event Counter Bank

This block is a small register bank on a 16-bit host read/write bus. It keeps a bank of sticky status registers, each bit of which is set by a single-cycle event pulse from the datapath. It also keeps a bank of event counters, each advanced by its own single-cycle increment pulse. One global control word holds two mode bits that can be changed at run time.

The first mode bit picks how status bits are cleared. In one setting a host read clears them. In the other, the host writes ones to the bits it wants cleared. The second mode bit picks what a counter does at its top value. It either holds there (saturates) or wraps to zero. The same bit also decides whether a host read clears the counter: in saturating mode a read clears it, and in wrapping mode a read leaves it unchanged.

Read data comes back one cycle after the read strobe, together with a valid flag. Events are never lost when they collide with a clearing read.

Top module: `stat_cnt_bank`

## Requirements
- R1: The control word is at address 0x001 and resets to 0xC000. Bit 15 is the status clear mode (1 = clear on read, 0 = clear by writing ones). Bit 14 is the counter mode (1 = saturate, 0 = wrap). Both bits can be written. Bits 13..0 always read as zero and ignore writes.
- R2: An event pulse on bit b of status register i sets that bit, and the bit stays set until it is cleared under the active clear mode.
- R3: In clear-on-read mode, a read of a status register returns its contents and then clears only the bits that were set before the read. An event that arrives in the same cycle as the read stays set after the read.
- R4: In clear-by-write mode, writing 1 to a status bit clears it and writing 0 leaves it unchanged. Reads do not change status registers in this mode.
- R5: In clear-on-read mode, host writes to status registers have no effect.
- R6: Each increment pulse raises its counter by exactly one, except at the top value in saturating mode.
- R7: In saturating mode, a counter stays at its top value (all ones in CNT_W bits) once it gets there. A read returns the value and clears the counter to zero. If an increment arrives in the same cycle as that read, the read returns the old value and the counter becomes 1.
- R8: In wrapping mode, a counter goes from its top value to zero on the next increment, and reads do not change it.
- R9: A read strobe gives host_rdata and host_rvalid in the next cycle. Status register i is at 0x010+i. Counter j is at 0x010+N_STAT+j and reads zero-extended to 16 bits. Any other address reads as zero.
- R10: Host writes to counter addresses have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_addr | input | AW | Register address |
| host_wdata | input | 16 | Write data |
| host_rdata | output | 16 | Read data, one cycle after host_rd |
| host_rvalid | output | 1 | High in the cycle host_rdata is valid |
| stat_evt | input | N_STAT*16 | Event pulses, bit 16*i+b sets bit b of status register i |
| cnt_inc | input | N_CNT | Increment pulses, one per counter |

## Verification
The hardest situations to reach from the ports are the collisions: an event or increment pulse in the very cycle a clearing read reaches the same register. The bench drives the read strobe and the pulse on the same falling edge, so both land on one rising edge. It then reads the register twice, once to see the old value and once to see what survived. Saturation and wrap are reached by using a 4-bit counter width and sweeping the number of increments past 15.

// File: rtl/stb_pkg.sv
package stb_pkg;
  localparam int DW        = 16;
  localparam int CTRL_ADDR = 'h001;
  localparam int BANK_BASE = 'h010;

  // Next value of a sticky status word: clear the masked bits, then add new events.
  function automatic logic [DW-1:0] stat_next(logic [DW-1:0] cur,
                                              logic [DW-1:0] evt,
                                              logic [DW-1:0] clr_mask);
    return (cur & ~clr_mask) | evt;
  endfunction

  // Build the control word from the two mode bits.
  function automatic logic [DW-1:0] ctrl_word(logic clr_on_read, logic sat_mode);
    return {clr_on_read, sat_mode, {(DW-2){1'b0}}};
  endfunction
endpackage

// File: rtl/stb_ctrl.sv
module stb_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [1:0] wr_mode,
  output logic       clr_on_read,
  output logic       sat_mode
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      clr_on_read <= 1'b1;
      sat_mode    <= 1'b1;
    end else if (wr_en) begin
      clr_on_read <= wr_mode[1];
      sat_mode    <= wr_mode[0];
    end
  end
endmodule

// File: rtl/stb_status.sv
module stb_status (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [stb_pkg::DW-1:0] evt,
  input  logic [stb_pkg::DW-1:0] clr_mask,
  output logic [stb_pkg::DW-1:0] stat_q
);
  always_ff @(posedge clk) begin
    if (!rst_n) stat_q <= '0;
    else        stat_q <= stb_pkg::stat_next(stat_q, evt, clr_mask);
  end
endmodule

// File: rtl/stb_counter.sv
module stb_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sat_mode,
  input  logic         inc,
  input  logic         rd_clr,
  output logic [W-1:0] cnt_q
);
  localparam logic [W-1:0] TOP = {W{1'b1}};
  localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

  // One step of the counter under the active overflow mode.
  function automatic logic [W-1:0] bump(logic [W-1:0] v, logic sat);
    if (sat && v == TOP) return v;
    return v + ONE;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n)      cnt_q <= '0;
    else if (rd_clr) cnt_q <= inc ? ONE : '0;
    else if (inc)    cnt_q <= bump(cnt_q, sat_mode);
  end
endmodule

// File: rtl/stat_cnt_bank.sv
module stat_cnt_bank #(
  parameter int N_STAT = 4,
  parameter int N_CNT  = 8,
  parameter int CNT_W  = 16,
  parameter int AW     = 12
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        host_wr,
  input  logic                        host_rd,
  input  logic [AW-1:0]               host_addr,
  input  logic [15:0]                 host_wdata,
  output logic [15:0]                 host_rdata,
  output logic                        host_rvalid,
  input  logic [N_STAT*16-1:0]        stat_evt,
  input  logic [N_CNT-1:0]            cnt_inc
);
  import stb_pkg::*;

  localparam int CNT_BASE = BANK_BASE + N_STAT;

  logic              clr_on_read, sat_mode;
  logic              ctrl_hit;
  logic [N_STAT-1:0] rd_stat, wr_stat;
  logic [N_CNT-1:0]  rd_cnt, cnt_rd_clr;
  logic [N_STAT*DW-1:0]   stat_flat;
  logic [N_CNT*CNT_W-1:0] cnt_flat;
  logic [DW-1:0]     rd_val;

  assign ctrl_hit = (host_addr == AW'(CTRL_ADDR));

  stb_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .wr_en       (host_wr && ctrl_hit),
    .wr_mode     (host_wdata[15:14]),
    .clr_on_read (clr_on_read),
    .sat_mode    (sat_mode)
  );

  for (genvar i = 0; i < N_STAT; i++) begin : g_stat
    logic [DW-1:0] clr_mask;
    assign rd_stat[i] = host_rd && (host_addr == AW'(BANK_BASE + i));
    assign wr_stat[i] = host_wr && (host_addr == AW'(BANK_BASE + i));
    assign clr_mask   = clr_on_read ? {DW{rd_stat[i]}}
                                    : (wr_stat[i] ? host_wdata : '0);
    stb_status stat_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt      (stat_evt[i*DW +: DW]),
      .clr_mask (clr_mask),
      .stat_q   (stat_flat[i*DW +: DW])
    );
  end

  for (genvar j = 0; j < N_CNT; j++) begin : g_cnt
    assign rd_cnt[j]     = host_rd && (host_addr == AW'(CNT_BASE + j));
    assign cnt_rd_clr[j] = rd_cnt[j] && sat_mode;
    stb_counter #(.W(CNT_W)) cnt_i (
      .clk      (clk),
      .rst_n    (rst_n),
      .sat_mode (sat_mode),
      .inc      (cnt_inc[j]),
      .rd_clr   (cnt_rd_clr[j]),
      .cnt_q    (cnt_flat[j*CNT_W +: CNT_W])
    );
  end

  always_comb begin
    rd_val = '0;
    if (ctrl_hit) rd_val = ctrl_word(clr_on_read, sat_mode);
    for (int i = 0; i < N_STAT; i++)
      if (host_addr == AW'(BANK_BASE + i)) rd_val = stat_flat[i*DW +: DW];
    for (int j = 0; j < N_CNT; j++)
      if (host_addr == AW'(CNT_BASE + j)) rd_val = DW'(cnt_flat[j*CNT_W +: CNT_W]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      host_rdata  <= '0;
      host_rvalid <= 1'b0;
    end else begin
      host_rvalid <= host_rd;
      if (host_rd) host_rdata <= rd_val;
    end
  end
endmodule

// File: rtl/stb_chk.sv
module stb_chk #(
  parameter int N_STAT = 4,
  parameter int N_CNT  = 8,
  parameter int CNT_W  = 16,
  parameter int AW     = 12
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   host_rd,
  input logic                   host_rvalid,
  input logic [AW-1:0]          host_addr,
  input logic [15:0]            host_rdata,
  input logic [N_STAT*16-1:0]   stat_evt,
  input logic [N_CNT-1:0]       cnt_inc,
  input logic [N_STAT*16-1:0]   stat_flat,
  input logic [N_CNT*CNT_W-1:0] cnt_flat,
  input logic                   sat_mode,
  input logic [N_CNT-1:0]       cnt_rd_clr
);
  // R9
  rvalid_follows_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_rd |=> host_rvalid);

  // R1
  ctrl_reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_rd && host_addr == AW'(1)) |=> (host_rdata[13:0] == 14'h0));

  // R2
  event_sets_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|stat_evt) |=> ((stat_flat & $past(stat_evt)) == $past(stat_evt)));

  for (genvar j = 0; j < N_CNT; j++) begin : g_c
    // R7
    sat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sat_mode && (&cnt_flat[j*CNT_W +: CNT_W]) && cnt_inc[j] && !cnt_rd_clr[j])
      |=> (&cnt_flat[j*CNT_W +: CNT_W]));
    // R8
    idle_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!cnt_inc[j] && !cnt_rd_clr[j]) |=> $stable(cnt_flat[j*CNT_W +: CNT_W]));
  end
endmodule

bind stat_cnt_bank stb_chk #(.N_STAT(N_STAT), .N_CNT(N_CNT), .CNT_W(CNT_W), .AW(AW)) chk_i (
  .clk(clk), .rst_n(rst_n), .host_rd(host_rd), .host_rvalid(host_rvalid),
  .host_addr(host_addr), .host_rdata(host_rdata), .stat_evt(stat_evt),
  .cnt_inc(cnt_inc), .stat_flat(stat_flat), .cnt_flat(cnt_flat),
  .sat_mode(sat_mode), .cnt_rd_clr(cnt_rd_clr)
);

// File: tb/stat_cnt_bank_tb_top.sv
module stat_cnt_bank_tb_top;
  localparam int NS = 2, NC = 2, CW = 4, AW = 12;
  localparam int TOPV = (1 << CW) - 1;

  logic clk = 1'b0, rst_n = 1'b0;
  logic host_wr = 0, host_rd = 0;
  logic [AW-1:0] host_addr = '0;
  logic [15:0] host_wdata = '0, host_rdata;
  logic host_rvalid;
  logic [NS*16-1:0] stat_evt = '0;
  logic [NC-1:0] cnt_inc = '0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  stat_cnt_bank #(.N_STAT(NS), .N_CNT(NC), .CNT_W(CW), .AW(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_rd(host_rd),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .host_rvalid(host_rvalid), .stat_evt(stat_evt), .cnt_inc(cnt_inc));

  task automatic check(string req, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // Read with optional simultaneous event and increment pulses.
  task automatic rd_x(int a, logic [NS*16-1:0] ev, logic [NC-1:0] inc, output logic [15:0] d);
    @(negedge clk);
    host_rd = 1; host_addr = AW'(a); stat_evt = ev; cnt_inc = inc;
    @(negedge clk);
    host_rd = 0; stat_evt = '0; cnt_inc = '0;
    d = host_rdata;
    check("R9 rvalid", {15'b0, host_rvalid}, 16'h1);
  endtask

  task automatic rd(int a, output logic [15:0] d);
    rd_x(a, '0, '0, d);
  endtask

  task automatic wr(int a, logic [15:0] v);
    @(negedge clk);
    host_wr = 1; host_addr = AW'(a); host_wdata = v;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic pulse_evt(int r, logic [15:0] p);
    @(negedge clk);
    stat_evt = '0; stat_evt[r*16 +: 16] = p;
    @(negedge clk);
    stat_evt = '0;
  endtask

  task automatic pulse_inc(int c, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); cnt_inc = '0; cnt_inc[c] = 1'b1;
      @(negedge clk); cnt_inc = '0;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] d;
    logic [15:0] pats [4];
    logic [15:0] masks [4];
    int expv;
    pats = '{16'h0001, 16'hA5A5, 16'hFFFF, 16'h8000};
    masks = '{16'h0000, 16'h00F0, 16'hF003, 16'hFFFF};
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset and R9 map reset state
    rd(1, d); check("R1 reset ctrl", d, 16'hC000);
    for (int a = 'h10; a < 'h10 + NS + NC; a++) begin
      rd(a, d); check("R9 reset reg", d, 16'h0);
    end
    // R1 reserved bits ignore writes
    wr(1, 16'hFFFF); rd(1, d); check("R1 write ones", d, 16'hC000);
    wr(1, 16'h3FFF); rd(1, d); check("R1 write zeros", d, 16'h0000);
    wr(1, 16'h4000); rd(1, d); check("R1 write sat", d, 16'h4000);
    wr(1, 16'hC000);

    // R2 R3 clear-on-read sweep
    for (int r = 0; r < NS; r++)
      for (int p = 0; p < 4; p++) begin
        pulse_evt(r, pats[p]);
        rd('h10 + r, d); check("R2 sticky", d, pats[p]);
        rd('h10 + r, d); check("R3 cleared by read", d, 16'h0);
      end
    // R3 event during clearing read
    pulse_evt(1, 16'h0003);
    rd_x('h11, {16'h0004, 16'h0000}, '0, d); check("R3 old value", d, 16'h0003);
    rd('h11, d); check("R3 event kept", d, 16'h0004);
    // R5 writes ignored in clear-on-read mode
    pulse_evt(0, 16'h00FF);
    wr('h10, 16'hFFFF); rd('h10, d); check("R5 write ignored", d, 16'h00FF);

    // R4 clear-by-write sweep
    wr(1, 16'h4000);
    for (int m = 0; m < 4; m++) begin
      pulse_evt(0, 16'hF0F3);
      rd('h10, d); check("R4 read", d, 16'hF0F3);
      rd('h10, d); check("R4 read no clear", d, 16'hF0F3);
      wr('h10, masks[m]);
      rd('h10, d); check("R4 masked clear", d, 16'hF0F3 & ~masks[m]);
      wr('h10, 16'hFFFF);
      rd('h10, d); check("R4 full clear", d, 16'h0);
    end

    // R6 R7 saturate sweep
    wr(1, 16'hC000);
    for (int n = 0; n <= 20; n++) begin
      pulse_inc(0, n);
      rd('h12, d); check("R7 saturate", d, 16'((n > TOPV) ? TOPV : n));
      rd('h12, d); check("R7 read clears", d, 16'h0);
    end
    // R7 increment during clearing read
    pulse_inc(0, 5);
    rd_x('h12, '0, 2'b01, d); check("R7 old on collide", d, 16'd5);
    rd('h12, d); check("R7 loads one", d, 16'd1);
    rd('h12, d); check("R7 then zero", d, 16'd0);
    // R10 counter writes ignored
    pulse_inc(1, 3);
    wr('h13, 16'h0007);
    rd('h13, d); check("R10 write ignored", d, 16'd3);

    // R6 R8 wrap sweep (counter 1 cleared by last read)
    wr(1, 16'h8000);
    expv = 0;
    for (int n = 0; n <= 20; n++) begin
      pulse_inc(1, n);
      expv = (expv + n) % (TOPV + 1);
      rd('h13, d); check("R8 wrap", d, 16'(expv));
      rd('h13, d); check("R8 read keeps", d, 16'(expv));
    end

    // R9 unmapped addresses
    rd('h000, d); check("R9 unmapped 0x000", d, 16'h0);
    rd('h020, d); check("R9 unmapped 0x020", d, 16'h0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule